// File: doc/BRIEF.md
# Two-Input Edge-Qualified Event Counter Control

This block turns activity on external pins and internal strobes into count requests for a timer counter. It watches two clock-like pins, A and B, and a trigger pin, each brought into the local clock domain through a synchronizer chain. It also takes an internal event strobe and the overflow and underflow strobes of a paired timer. Each pin edge can be qualified by the level of the partner pin. This allows quadrature encoders to be decoded and two timers to be chained.

Two 13-bit masks choose which qualified conditions request an upward count and which request a downward count. Each cycle, the block issues at most one registered, single-cycle pulse on `cnt_up` or on `cnt_dn`. If both directions are requested in the same cycle, the requests cancel and no pulse is issued. The counter itself lives outside this block.

Top module: `qec_count_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `cnt_up` and `cnt_dn` are low.
- R2: Mask bits 0..3 select an edge on B qualified by the level of A: bit 0 is B rising with A low, bit 1 is B falling with A low, bit 2 is B rising with A high, and bit 3 is B falling with A high. The level of A is its synchronized value in the cycle the B edge is seen.
- R3: Mask bits 4..7 select an edge on A qualified by the level of B: bit 4 is A rising with B low, bit 5 is A falling with B low, bit 6 is A rising with B high, and bit 7 is A falling with B high.
- R4: Mask bit 8 selects a rising edge on the trigger pin, and bit 9 selects a falling edge on it; the level of A and B is irrelevant.
- R5: Mask bit 10 selects the internal event strobe. A strobe that is high for one cycle in which a rising clock edge samples it produces a pulse visible right after that edge.
- R6: Mask bit 11 selects the paired timer's overflow strobe, and bit 12 selects its underflow strobe, with the same one-edge latency as R5.
- R7: A mask bit that is zero never causes a count; with both masks at zero, no pulse is ever issued.
- R8: When the up request and the down request are both true in one cycle, neither `cnt_up` nor `cnt_dn` is pulsed.
- R9: A pin change sampled at rising edge k gives a pulse that is high only between edges k+2 and k+3 (two synchronizer flops plus the output register).
- R10: With `up_mask` = 0x96 (bits 1, 2, 4, 7), the full pin sequence AB = 00,10,11,01,00 gives four up pulses and no down pulse. With `dn_mask` = 0x69, the reverse sequence gives four down pulses.
- R11: A single pin edge produces exactly one single-cycle pulse, no matter how long the new level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Asynchronous clock pin A |
| pin_b | input | 1 | Asynchronous clock pin B |
| pin_trig | input | 1 | Asynchronous trigger pin |
| evt_strobe | input | 1 | Internal event strobe, synchronous to clk |
| pair_ovf | input | 1 | Paired timer overflow strobe, synchronous |
| pair_udf | input | 1 | Paired timer underflow strobe, synchronous |
| up_mask | input | 13 | Condition enables for counting up |
| dn_mask | input | 13 | Condition enables for counting down |
| cnt_up | output | 1 | Registered single-cycle count-up request |
| cnt_dn | output | 1 | Registered single-cycle count-down request |

## Verification
The bound checker watches several properties on every cycle. It checks that the two outputs are never high together, and that a pulse never appears without a nonzero mask in the cycle before. It checks that a masked strobe with the opposite mask clear always yields its pulse one edge later, that colliding strobe requests yield nothing, and that reset quiets the outputs. The pin-driven behaviour can only be shown by the bench's scenarios: the qualification of each of the ten pin conditions, the three-edge pin latency, the single pulse per edge, and the quadrature counts. The bench sweeps every old/new pin state pair against every single-bit mask in both directions and compares the result with a model computed from the requirement tables.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int NUM_COND = 13;
  localparam int NUM_PINS = 3;

  // pin lanes inside the synchronized vector
  localparam int PIN_A = 0;
  localparam int PIN_B = 1;
  localparam int PIN_T = 2;

  // condition indices (their positions are the mask bit positions)
  localparam int C_TRIG_RISE = 8;
  localparam int C_TRIG_FALL = 9;
  localparam int C_EVENT     = 10;
  localparam int C_PAIR_OVF  = 11;
  localparam int C_PAIR_UDF  = 12;

  typedef logic [NUM_COND-1:0] cond_vec_t;
  typedef logic [NUM_PINS-1:0] pin_vec_t;
endpackage

// File: rtl/qec_sync.sv
module qec_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qec_edge.sv
module qec_edge #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cur;
  end

  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;
endmodule

// File: rtl/qec_cond_vec.sv
module qec_cond_vec
  import qec_pkg::*;
(
  input  pin_vec_t  lvl,
  input  pin_vec_t  rise,
  input  pin_vec_t  fall,
  input  logic      evt,
  input  logic      ovf,
  input  logic      udf,
  output cond_vec_t cond
);
  // g = 0: edge on B, level of A (bits 0..3); g = 1: edge on A, level of B (bits 4..7)
  for (genvar g = 0; g < 2; g++) begin : g_edge_pin
    localparam int EP = (g == 0) ? PIN_B : PIN_A;
    localparam int OP = (g == 0) ? PIN_A : PIN_B;
    for (genvar lv = 0; lv < 2; lv++) begin : g_level
      logic lvl_ok;
      assign lvl_ok = (lv == 0) ? ~lvl[OP] : lvl[OP];
      assign cond[4*g + 2*lv]     = rise[EP] & lvl_ok;
      assign cond[4*g + 2*lv + 1] = fall[EP] & lvl_ok;
    end
  end

  assign cond[C_TRIG_RISE] = rise[PIN_T];
  assign cond[C_TRIG_FALL] = fall[PIN_T];
  assign cond[C_EVENT]     = evt;
  assign cond[C_PAIR_OVF]  = ovf;
  assign cond[C_PAIR_UDF]  = udf;
endmodule

// File: rtl/qec_count_ctrl.sv
module qec_count_ctrl
  import qec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pin_a,
  input  logic                pin_b,
  input  logic                pin_trig,
  input  logic                evt_strobe,
  input  logic                pair_ovf,
  input  logic                pair_udf,
  input  logic [NUM_COND-1:0] up_mask,
  input  logic [NUM_COND-1:0] dn_mask,
  output logic                cnt_up,
  output logic                cnt_dn
);
  pin_vec_t  raw_pins, sync_pins, pin_rise, pin_fall;
  cond_vec_t cond;
  logic      want_up, want_dn;

  assign raw_pins = {pin_trig, pin_b, pin_a};

  qec_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_pins),
    .q   (sync_pins)
  );

  qec_edge #(.WIDTH(NUM_PINS)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .cur  (sync_pins),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  qec_cond_vec u_cond (
    .lvl  (sync_pins),
    .rise (pin_rise),
    .fall (pin_fall),
    .evt  (evt_strobe),
    .ovf  (pair_ovf),
    .udf  (pair_udf),
    .cond (cond)
  );

  assign want_up = |(cond & up_mask);
  assign want_dn = |(cond & dn_mask);

  // opposing requests in one cycle cancel
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_up <= 1'b0;
      cnt_dn <= 1'b0;
    end else begin
      cnt_up <= want_up & ~want_dn;
      cnt_dn <= want_dn & ~want_up;
    end
  end
endmodule

// File: rtl/qec_count_ctrl_chk.sv
module qec_count_ctrl_chk
  import qec_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                evt_strobe,
  input logic                pair_ovf,
  input logic [NUM_COND-1:0] up_mask,
  input logic [NUM_COND-1:0] dn_mask,
  input logic                cnt_up,
  input logic                cnt_dn
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!cnt_up && !cnt_dn));

  assert_event_up_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(evt_strobe && up_mask[C_EVENT] && (dn_mask == '0))) |-> cnt_up);

  assert_pair_ovf_down_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pair_ovf && dn_mask[C_PAIR_OVF] && (up_mask == '0))) |-> cnt_dn);

  assert_up_needs_mask_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_up |-> ($past(up_mask) != '0));

  assert_dn_needs_mask_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_dn |-> ($past(dn_mask) != '0));

  assert_never_both_R8: assert property (@(posedge clk) disable iff (rst)
    !(cnt_up && cnt_dn));

  assert_strobe_cancel_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(evt_strobe && up_mask[C_EVENT] && dn_mask[C_EVENT]))
      |-> (!cnt_up && !cnt_dn));
endmodule

bind qec_count_ctrl qec_count_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_strobe (evt_strobe),
  .pair_ovf   (pair_ovf),
  .up_mask    (up_mask),
  .dn_mask    (dn_mask),
  .cnt_up     (cnt_up),
  .cnt_dn     (cnt_dn)
);

// File: tb/qec_count_ctrl_tb.sv
module qec_count_ctrl_tb;
  logic clk = 1'b0;
  logic rst;
  logic pin_a, pin_b, pin_trig, evt_strobe, pair_ovf, pair_udf;
  logic [12:0] up_mask, dn_mask;
  logic cnt_up, cnt_dn;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  qec_count_ctrl u_dut (
    .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b), .pin_trig(pin_trig),
    .evt_strobe(evt_strobe), .pair_ovf(pair_ovf), .pair_udf(pair_udf),
    .up_mask(up_mask), .dn_mask(dn_mask), .cnt_up(cnt_up), .cnt_dn(cnt_dn)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_pins(logic [2:0] p);
    pin_a = p[0]; pin_b = p[1]; pin_trig = p[2];
  endtask

  task automatic window(int n, output int u, output int d);
    u = 0; d = 0;
    repeat (n) begin
      step();
      u += int'(cnt_up);
      d += int'(cnt_dn);
    end
  endtask

  // expected conditions from old and new pin states, bit0=A bit1=B bit2=trigger
  function automatic logic [12:0] model(logic [2:0] o, logic [2:0] n);
    logic ar, af, br, bf, a, b;
    logic [12:0] v = '0;
    ar = !o[0] && n[0]; af = o[0] && !n[0];
    br = !o[1] && n[1]; bf = o[1] && !n[1];
    a = n[0]; b = n[1];
    v[0] = br && !a; v[1] = bf && !a; v[2] = br && a; v[3] = bf && a;
    v[4] = ar && !b; v[5] = af && !b; v[6] = ar && b; v[7] = af && b;
    v[8] = !o[2] && n[2]; v[9] = o[2] && !n[2];
    return v;
  endfunction

  initial begin
    int u, d;
    logic [2:0] fwd [4];
    fwd[0] = 3'b001; fwd[1] = 3'b011; fwd[2] = 3'b010; fwd[3] = 3'b000;
    rst = 1'b1;
    set_pins(3'b000);
    evt_strobe = 0; pair_ovf = 0; pair_udf = 0;
    up_mask = '0; dn_mask = '0;
    repeat (3) step();
    up_mask = 13'h1FFF;
    evt_strobe = 1;
    step();
    chk("R1 up in reset", int'(cnt_up), 0);
    chk("R1 dn in reset", int'(cnt_dn), 0);
    evt_strobe = 0; up_mask = '0;
    rst = 1'b0;
    step();
    chk("R1 up after reset", int'(cnt_up), 0);
    chk("R1 dn after reset", int'(cnt_dn), 0);

    // R2 R3 R4: sweep all old/new pin pairs against every single pin-condition bit
    for (int o = 0; o < 8; o++)
      for (int n = 0; n < 8; n++)
        for (int i = 0; i < 10; i++)
          for (int dir = 0; dir < 2; dir++) begin
            logic [12:0] e;
            string tag;
            up_mask = '0; dn_mask = '0;
            set_pins(3'(o));
            repeat (5) step();
            if (dir == 0) up_mask = 13'(1 << i); else dn_mask = 13'(1 << i);
            set_pins(3'(n));
            window(5, u, d);
            e = model(3'(o), 3'(n));
            tag = (i < 4) ? "R2" : (i < 8) ? "R3" : "R4";
            chk($sformatf("%s bit%0d dir%0d %0d->%0d up", tag, i, dir, o, n), u, (dir == 0) ? int'(e[i]) : 0);
            chk($sformatf("%s bit%0d dir%0d %0d->%0d dn", tag, i, dir, o, n), d, (dir == 1) ? int'(e[i]) : 0);
          end
    up_mask = '0; dn_mask = '0;
    set_pins(3'b000);
    repeat (5) step();

    // R9 R11: latency and single pulse of an A rising edge with B low
    up_mask = 13'h0010;
    set_pins(3'b001);
    step(); chk("R9 edge1", int'(cnt_up), 0);
    step(); chk("R9 edge2", int'(cnt_up), 0);
    step(); chk("R9 edge3", int'(cnt_up), 1);
    step(); chk("R11 single pulse", int'(cnt_up), 0);
    window(6, u, d);
    chk("R11 held level no more pulses", u, 0);
    up_mask = '0;
    set_pins(3'b000);
    repeat (5) step();

    // R5 R6: each strobe against each strobe mask bit, both directions
    for (int s = 0; s < 3; s++)
      for (int j = 10; j < 13; j++)
        for (int dir = 0; dir < 2; dir++) begin
          int hit;
          string tag;
          hit = (j == 10 + s) ? 1 : 0;
          tag = (s == 0) ? "R5" : "R6";
          if (dir == 0) up_mask = 13'(1 << j); else dn_mask = 13'(1 << j);
          evt_strobe = (s == 0); pair_ovf = (s == 1); pair_udf = (s == 2);
          step();
          chk($sformatf("%s strobe%0d bit%0d dir%0d up", tag, s, j, dir), int'(cnt_up), (dir == 0) ? hit : 0);
          chk($sformatf("%s strobe%0d bit%0d dir%0d dn", tag, s, j, dir), int'(cnt_dn), (dir == 1) ? hit : 0);
          evt_strobe = 0; pair_ovf = 0; pair_udf = 0;
          step();
          chk($sformatf("%s strobe%0d bit%0d one cycle", tag, s, j), int'(cnt_up | cnt_dn), 0);
          up_mask = '0; dn_mask = '0;
        end

    // R7: zero masks with full activity
    begin
      int tu = 0, td = 0;
      for (int k = 0; k < 8; k++) begin
        set_pins(fwd[k % 4] | 3'((k & 1) << 2));
        evt_strobe = 1; pair_ovf = 1; pair_udf = 1;
        step();
        evt_strobe = 0; pair_ovf = 0; pair_udf = 0;
        window(4, u, d);
        tu += u + int'(cnt_up); td += d;
      end
      chk("R7 zero mask up", tu, 0);
      chk("R7 zero mask dn", td, 0);
      set_pins(3'b000);
      repeat (5) step();
    end

    // R8: collisions
    up_mask = 13'h0400; dn_mask = 13'h0400;
    evt_strobe = 1; step(); evt_strobe = 0;
    chk("R8 same strobe both masks up", int'(cnt_up), 0);
    chk("R8 same strobe both masks dn", int'(cnt_dn), 0);
    up_mask = 13'h0400; dn_mask = 13'h0800;
    evt_strobe = 1; pair_ovf = 1; step(); evt_strobe = 0; pair_ovf = 0;
    chk("R8 two strobes opposite up", int'(cnt_up), 0);
    chk("R8 two strobes opposite dn", int'(cnt_dn), 0);
    evt_strobe = 1; step(); evt_strobe = 0;
    chk("R8 lone strobe still counts", int'(cnt_up), 1);
    up_mask = 13'h0010; dn_mask = 13'h0010;
    set_pins(3'b001);
    window(5, u, d);
    chk("R8 pin edge both masks", u + d, 0);
    up_mask = '0; dn_mask = '0;
    set_pins(3'b000);
    repeat (5) step();

    // R10: quadrature, two forward rotations then two reverse
    up_mask = 13'h0096; dn_mask = 13'h0069;
    begin
      int tu = 0, td = 0;
      for (int r = 0; r < 8; r++) begin
        set_pins(fwd[r % 4]);
        window(4, u, d);
        tu += u; td += d;
      end
      chk("R10 forward up", tu, 8);
      chk("R10 forward dn", td, 0);
      tu = 0; td = 0;
      for (int r = 0; r < 8; r++) begin
        set_pins(fwd[(6 - r) & 3]);
        window(4, u, d);
        tu += u; td += d;
      end
      chk("R10 reverse up", tu, 0);
      chk("R10 reverse dn", td, 8);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule